// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the working configuration of a clock synthesizer: a 9-bit feedback multiplier M, a 2-bit output divider code N and a 2-bit debug selector T. The configuration arrives on one of two paths. The first is a set of parallel pins qualified by a latch strobe. The second is a three-wire serial port with data, clock and load lines. Both paths write the same active registers. A debug pin shows one of four internal signals, chosen by T.

All logic runs in one fast system clock domain. The strobe, the serial clock, the serial load line, the serial data line and the divider-reset request pass through two-flop synchronizers. Edges of these signals are detected in the system clock domain. When the strobe is held low, hardwired parallel pins become the configuration as soon as reset is released. A warning flag is raised when M lies outside the range the loop can lock to. The flag only warns and never blocks a load.

Top module: `synth_cfg_loader`

## Requirements
- R1: While rst_n is low, cfg_m, cfg_n, cfg_t and test_pin are all 0. After release with pin_latch low, cfg_m and cfg_n take the pin_m and pin_n values, so hardwired pins form the power-up configuration.
- R2: While pin_latch is low (parallel mode), cfg_m and cfg_n follow pin_m and pin_n continuously. cfg_t keeps its value.
- R3: A rising edge on pin_latch freezes cfg_m and cfg_n at the pin values present at that edge. Later pin changes have no effect while pin_latch stays high.
- R4: The serial shift register advances only on rising edges of ser_clk that occur while pin_latch is high. Serial clock edges in parallel mode leave its contents unchanged.
- R5: A serial frame is 14 bits, first bit first: T1, T0, a spare slot, N1, N0, then M8 down to M0. The spare slot value has no effect on cfg_m, cfg_n or cfg_t.
- R6: A rising edge on ser_ld while pin_latch is high copies the shift register into cfg_t, cfg_n and cfg_m.
- R7: While pin_latch is high and ser_ld is low, serial clocking alters only the shift register. cfg_m, cfg_n and cfg_t hold the values present when ser_ld fell.
- R8: While pin_latch and ser_ld are both high, every serial clock rising edge shifts and copies the new register contents into cfg_t, cfg_n and cfg_m (transparent loading).
- R9: With pin_latch high and div_rst low, test_pin shows the signal selected by cfg_t. Code 0 gives 0. Code 1 gives the shift register's oldest bit (bit 13, the next bit to leave). Code 2 gives fbdiv_mon. Code 3 gives halfclk_mon.
- R10: test_pin is 0 whenever pin_latch is low, for any cfg_t code.
- R11: div_rst high drives test_pin to 0 and leaves cfg_m, cfg_n and cfg_t unchanged.
- R12: m_warn is 1 exactly when cfg_m is below 8 or above 28.
- R13: A falling edge on pin_latch returns the block to parallel mode. The pins then override a serially loaded M and N, while cfg_t is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_m | input | 9 | Parallel feedback multiplier value |
| pin_n | input | 2 | Parallel output divider code |
| pin_latch | input | 1 | Parallel latch strobe; low = transparent, rising = latch, high = serial port enabled |
| ser_clk | input | 1 | Serial clock, sampled on its rising edges |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load; rising = transfer, high = transparent, low = hold |
| div_rst | input | 1 | Divider reset request; forces test_pin low, keeps configuration |
| fbdiv_mon | input | 1 | Feedback divider output, observed for debug |
| halfclk_mon | input | 1 | Half-rate output clock, observed for debug |
| cfg_m | output | 9 | Active feedback multiplier |
| cfg_n | output | 2 | Active output divider code |
| cfg_t | output | 2 | Active debug selector code |
| test_pin | output | 1 | Debug output |
| m_warn | output | 1 | Active M outside the lockable range |

## Verification
The state hardest to reach from the ports is a shift register whose contents differ from the active configuration. Such a state can only be seen afterwards, through a load that moves no new bits, or through debug code 1. The stimulus first loads a known frame, then drops to parallel mode and toggles the serial clock with other data. It then raises the strobe again and pulses ser_ld without any clock edges, so the untouched frame must appear. The same route, shifting one bit with ser_ld low under code 1, shows the register moving while the configuration holds.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  parameter int M_W = 9;
  parameter int N_W = 2;
  parameter int T_W = 2;
  localparam int SPARE_W = 1;
  localparam int FRAME_W = T_W + SPARE_W + N_W + M_W;
  // field positions inside the serial frame, M0 at bit 0 (last bit shifted)
  localparam int FR_M_LSB = 0;
  localparam int FR_N_LSB = M_W;
  localparam int FR_SPARE = M_W + N_W;
  localparam int FR_T_LSB = M_W + N_W + SPARE_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'd0,
    TSEL_SHIFT = 2'd1,
    TSEL_FBDIV = 2'd2,
    TSEL_HALF  = 2'd3
  } tsel_e;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } syn_cfg_s;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           bit_i,
  output logic           msb_o,
  output syn_cfg_s       frame_next_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign msb_o          = sr_q[FRAME_W-1];
  assign frame_next_o.t = sr_d[FR_T_LSB +: T_W];
  assign frame_next_o.n = sr_d[FR_N_LSB +: N_W];
  assign frame_next_o.m = sr_d[FR_M_LSB +: M_W];
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int LOCK_MIN = 8,
  parameter int LOCK_MAX = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pins_ld,
  input  logic           frame_ld,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_n,
  input  syn_cfg_s       frame,
  output syn_cfg_s       cfg_o,
  output logic           warn_o
);
  syn_cfg_s cfg_q, cfg_d;
  logic     warn_q, warn_d;
  logic     cfg_en;

  assign cfg_en = pins_ld | frame_ld;

  always_comb begin
    cfg_d = cfg_q;
    if (pins_ld) begin
      cfg_d.m = pin_m;
      cfg_d.n = pin_n;
    end else if (frame_ld) begin
      cfg_d = frame;
    end
    warn_d = (int'(cfg_d.m) < LOCK_MIN) || (int'(cfg_d.m) > LOCK_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      warn_q <= 1'b0;
    end else if (cfg_en) begin
      cfg_q  <= cfg_d;
      warn_q <= warn_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign warn_o = warn_q;
endmodule

// File: rtl/synth_cfg_testmux.sv
module synth_cfg_testmux
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           force_low,
  input  logic [T_W-1:0] code,
  input  logic           shift_msb,
  input  logic           fbdiv,
  input  logic           halfclk,
  output logic           test_o
);
  logic test_q, test_d;

  always_comb begin
    unique case (tsel_e'(code))
      TSEL_LOW:   test_d = 1'b0;
      TSEL_SHIFT: test_d = shift_msb;
      TSEL_FBDIV: test_d = fbdiv;
      TSEL_HALF:  test_d = halfclk;
      default:    test_d = 1'b0;
    endcase
    if (force_low) test_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= test_d;
  end

  assign test_o = test_q;
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_MIN    = 8,
  parameter int LOCK_MAX    = 28
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] pin_m,
  input  logic [N_W-1:0] pin_n,
  input  logic           pin_latch,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           div_rst,
  input  logic           fbdiv_mon,
  input  logic           halfclk_mon,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic           test_pin,
  output logic           m_warn
);
  // synchronizer channel indices
  localparam int CH_SCLK = 0;
  localparam int CH_SDAT = 1;
  localparam int CH_LD   = 2;
  localparam int CH_LAT  = 3;
  localparam int CH_DRST = 4;
  localparam int N_CH    = 5;
  localparam int N_EDGE  = 3;

  logic [N_CH-1:0]   raw_in, sync_lvl;
  logic [N_EDGE-1:0] edge_prev_q;

  logic     sclk_lvl, sdat_lvl, ld_lvl, par_lvl, drst_lvl;
  logic     sclk_prev, ld_prev, par_prev;
  logic     sclk_rise, ld_rise;
  logic     shift_en, pins_ld, frame_ld, force_low;
  logic     sr_msb;
  syn_cfg_s frame_next, cfg_q;

  assign raw_in[CH_SCLK] = ser_clk;
  assign raw_in[CH_SDAT] = ser_dat;
  assign raw_in[CH_LD]   = ser_ld;
  assign raw_in[CH_LAT]  = pin_latch;
  assign raw_in[CH_DRST] = div_rst;

  synth_cfg_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .lvl_o   (sync_lvl)
  );

  assign sclk_lvl = sync_lvl[CH_SCLK];
  assign sdat_lvl = sync_lvl[CH_SDAT];
  assign ld_lvl   = sync_lvl[CH_LD];
  assign par_lvl  = sync_lvl[CH_LAT];
  assign drst_lvl = sync_lvl[CH_DRST];

  // one extra stage for edge detection on the three control lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= '0;
    else        edge_prev_q <= {par_lvl, ld_lvl, sclk_lvl};
  end

  assign sclk_prev = edge_prev_q[0];
  assign ld_prev   = edge_prev_q[1];
  assign par_prev  = edge_prev_q[2];
  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign ld_rise   = ld_lvl & ~ld_prev;

  // mode decode: parallel path owns the registers while the strobe is low
  // and on the cycle it rises; the serial path writes only after that
  assign shift_en  = par_lvl & sclk_rise;
  assign pins_ld   = ~(par_lvl & par_prev);
  assign frame_ld  = par_lvl & par_prev & ld_lvl & (ld_rise | sclk_rise);
  assign force_low = ~par_lvl | drst_lvl;

  synth_cfg_shift u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .bit_i        (sdat_lvl),
    .msb_o        (sr_msb),
    .frame_next_o (frame_next)
  );

  synth_cfg_regs #(.LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_ld  (pins_ld),
    .frame_ld (frame_ld),
    .pin_m    (pin_m),
    .pin_n    (pin_n),
    .frame    (frame_next),
    .cfg_o    (cfg_q),
    .warn_o   (m_warn)
  );

  synth_cfg_testmux u_tmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_low (force_low),
    .code      (cfg_q.t),
    .shift_msb (sr_msb),
    .fbdiv     (fbdiv_mon),
    .halfclk   (halfclk_mon),
    .test_o    (test_pin)
  );

  assign cfg_m = cfg_q.m;
  assign cfg_n = cfg_q.n;
  assign cfg_t = cfg_q.t;
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
  import synth_cfg_pkg::*;
#(
  parameter int LOCK_MIN = 8,
  parameter int LOCK_MAX = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_lvl,
  input logic           par_prev,
  input logic           ld_lvl,
  input logic           ld_prev,
  input logic           sr_msb,
  input syn_cfg_s       frame_next,
  input logic [M_W-1:0] pin_m,
  input logic [M_W-1:0] cfg_m,
  input logic [N_W-1:0] cfg_n,
  input logic [T_W-1:0] cfg_t,
  input logic           test_pin,
  input logic           m_warn
);
  assert_parallel_test_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lvl |=> !test_pin);

  assert_code_zero_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t == 2'd0) |=> !test_pin);

  assert_pins_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lvl |=> (cfg_m == $past(pin_m)));

  assert_shift_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lvl |=> $stable(sr_msb));

  assert_load_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_lvl && par_prev && ld_lvl && !ld_prev) |=> (cfg_m == $past(frame_next.m)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_lvl && par_prev && !ld_lvl) |=> $stable({cfg_t, cfg_n, cfg_m}));

  assert_warn_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    m_warn |-> ((int'(cfg_m) < LOCK_MIN) || (int'(cfg_m) > LOCK_MAX)));
endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(.LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_lvl    (par_lvl),
  .par_prev   (par_prev),
  .ld_lvl     (ld_lvl),
  .ld_prev    (ld_prev),
  .sr_msb     (sr_msb),
  .frame_next (frame_next),
  .pin_m      (pin_m),
  .cfg_m      (cfg_m),
  .cfg_n      (cfg_n),
  .cfg_t      (cfg_t),
  .test_pin   (test_pin),
  .m_warn     (m_warn)
);

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] pin_m;
  logic [1:0] pin_n;
  logic       pin_latch, ser_clk, ser_dat, ser_ld, div_rst, fbdiv_mon, halfclk_mon;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n, cfg_t;
  logic       test_pin, m_warn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [13:0] sr_m;
  logic [8:0]  em;
  logic [1:0]  en, et;

  always #2.5 clk = ~clk;

  synth_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .pin_m(pin_m), .pin_n(pin_n), .pin_latch(pin_latch),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .div_rst(div_rst),
    .fbdiv_mon(fbdiv_mon), .halfclk_mon(halfclk_mon), .cfg_m(cfg_m), .cfg_n(cfg_n),
    .cfg_t(cfg_t), .test_pin(test_pin), .m_warn(m_warn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_warn(input logic [8:0] m);
    return (m < 9'd8) || (m > 9'd28);
  endfunction

  function automatic logic exp_test();
    if (!pin_latch || div_rst) return 1'b0;
    case (et)
      2'd0:    return 1'b0;
      2'd1:    return sr_m[13];
      2'd2:    return fbdiv_mon;
      default: return halfclk_mon;
    endcase
  endfunction

  task automatic check_cfg(input string req);
    check({req, " cfg_m"}, 32'(cfg_m), 32'(em));
    check({req, " cfg_n"}, 32'(cfg_n), 32'(en));
    check({req, " cfg_t"}, 32'(cfg_t), 32'(et));
    check({req, " m_warn"}, 32'(m_warn), 32'(exp_warn(em)));
  endtask

  task automatic check_test(input string req);
    check({req, " test_pin"}, 32'(test_pin), 32'(exp_test()));
  endtask

  task automatic set_pins(input logic [8:0] m, input logic [1:0] n);
    pin_m = m; pin_n = n;
    if (!pin_latch) begin em = m; en = n; end
    tick(6);
  endtask

  task automatic set_latch(input logic v);
    pin_latch = v;
    if (!v) begin em = pin_m; en = pin_n; end
    tick(6);
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    tick(4);
    ser_clk = 1'b1;
    if (pin_latch) begin
      sr_m = {sr_m[12:0], b};
      if (ser_ld) begin et = sr_m[13:12]; en = sr_m[10:9]; em = sr_m[8:0]; end
    end
    tick(4);
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic ser_frame(input logic [1:0] t, input logic spare, input logic [1:0] n,
                           input logic [8:0] m);
    logic [13:0] f;
    f = {t, spare, n, m};
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic ld_pulse();
    ser_ld = 1'b1;
    if (pin_latch) begin et = sr_m[13:12]; en = sr_m[10:9]; em = sr_m[8:0]; end
    tick(6);
    ser_ld = 1'b0;
    tick(6);
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] rm;
    logic [1:0] rn, rt;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    pin_m = 9'd20; pin_n = 2'd1; pin_latch = 1'b0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_ld = 1'b0; div_rst = 1'b0;
    fbdiv_mon = 1'b0; halfclk_mon = 1'b0;
    sr_m = '0; em = '0; en = '0; et = '0;
    tick(4);
    // R1: reset state
    check("R1 reset cfg_m", 32'(cfg_m), 0);
    check("R1 reset cfg_t", 32'(cfg_t), 0);
    check("R1 reset test_pin", 32'(test_pin), 0);
    rst_n = 1'b1;
    em = pin_m; en = pin_n;
    tick(6);
    check_cfg("R1 power-up from pins");

    // R2: pins flow through in parallel mode
    set_pins(9'd25, 2'd3); check_cfg("R2 pins a");
    set_pins(9'd9,  2'd0); check_cfg("R2 pins b");

    // R3: latch freezes pins
    set_latch(1'b1);
    set_pins(9'd300, 2'd2);
    check_cfg("R3 latched ignore pins");

    // R5/R6: frame load with spare slot 1, then spare slot 0
    ser_frame(2'd2, 1'b1, 2'd1, 9'd18);
    check_cfg("R7 hold before load");
    ld_pulse();
    check_cfg("R5 R6 frame spare=1");
    check(  "R6 cfg_m value", 32'(cfg_m), 18);
    ser_frame(2'd3, 1'b0, 2'd2, 9'd27);
    ld_pulse();
    check_cfg("R5 R6 frame spare=0");

    // R7: shifting with load low leaves config
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    check_cfg("R7 hold after extra bits");

    // R4: parallel-mode clocks must not disturb the shift register
    ser_frame(2'd0, 1'b1, 2'd3, 9'd11);
    set_latch(1'b0);
    check_cfg("R13 pins override serial");
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    set_latch(1'b1);
    ld_pulse();
    check_cfg("R4 frame survives parallel clocks");
    check("R4 cfg_m", 32'(cfg_m), 11);

    // R8: transparent loading while ser_ld high
    ser_ld = 1'b1;
    et = sr_m[13:12]; en = sr_m[10:9]; em = sr_m[8:0];
    tick(6);
    for (int i = 0; i < 6; i++) begin
      ser_bit(1'(i % 2));
      check_cfg("R8 transparent bit");
    end
    ser_ld = 1'b0;
    tick(6);

    // R9: test multiplexer codes
    ser_frame(2'd1, 1'b0, 2'd0, 9'd10); ld_pulse(); tick(4);
    check_test("R9 code1 frame msb");
    ser_bit(1'b0); tick(4);
    check_test("R9 code1 after shift");
    check_cfg("R7 code1 hold");
    ser_frame(2'd2, 1'b0, 2'd0, 9'd10); ld_pulse();
    fbdiv_mon = 1'b1; tick(6); check_test("R9 code2 fb=1");
    fbdiv_mon = 1'b0; tick(6); check_test("R9 code2 fb=0");
    ser_frame(2'd3, 1'b0, 2'd0, 9'd10); ld_pulse();
    halfclk_mon = 1'b1; tick(6); check_test("R9 code3 half=1");
    ser_frame(2'd0, 1'b0, 2'd0, 9'd10); ld_pulse(); tick(4);
    check_test("R9 code0");

    // R11: divider reset keeps config, test low
    ser_frame(2'd3, 1'b0, 2'd1, 9'd22); ld_pulse(); tick(4);
    check("R11 pre test_pin", 32'(test_pin), 1);
    div_rst = 1'b1; tick(8);
    check("R11 test_pin low", 32'(test_pin), 0);
    check_cfg("R11 cfg kept");
    div_rst = 1'b0; tick(8);
    check("R11 test_pin back", 32'(test_pin), 1);

    // R10: parallel mode forces test low with code 3 and half=1
    set_latch(1'b0); tick(2);
    check("R10 test_pin low", 32'(test_pin), 0);
    check_cfg("R13 cfg_t retained");

    // R12: lock range boundaries
    set_pins(9'd7,  2'd0); check("R12 m=7",  32'(m_warn), 1);
    set_pins(9'd8,  2'd0); check("R12 m=8",  32'(m_warn), 0);
    set_pins(9'd28, 2'd0); check("R12 m=28", 32'(m_warn), 0);
    set_pins(9'd29, 2'd0); check("R12 m=29", 32'(m_warn), 1);

    // random mix of parallel and serial traffic
    for (int it = 0; it < 30; it++) begin
      rm = 9'($urandom); rn = 2'($urandom); rt = 2'($urandom);
      fbdiv_mon = 1'($urandom); halfclk_mon = 1'($urandom);
      if ($urandom % 3 == 0) begin
        if (pin_latch) set_latch(1'b0);
        set_pins(rm, rn);
        check_cfg("R2 random pins");
        check_test("R10 random");
      end else begin
        if (!pin_latch) set_latch(1'b1);
        ser_frame(rt, 1'($urandom), rn, rm);
        ld_pulse(); tick(4);
        check_cfg("R6 random frame");
        check_test("R9 random");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule